// File: doc/BRIEF.md
# Dual-Output Serial Flash Read Master

This block sits on the host side of a serial flash. It reads a run of consecutive bytes using the dual-output fast read command. A single start pulse supplies a 24-bit byte address and a byte count. The block then selects the flash and sends the command byte and the address one bit per serial clock on the shared data line. After a fixed run of dummy clocks it releases its driver on that line and gathers the returned data two bits per serial clock, one bit from each of the two data lines.

Each completed byte goes into a one-entry output register and leaves on a valid/ready stream. When that register is full and the consumer is not ready, the serial clock stops so that no byte is lost. The serial clock runs at a fixed fraction of the system clock, set by a parameter that gives the length of each half period in system clocks.

Top module: `dual_spi_read_master`

## Requirements
- R1: While reset is applied and afterwards until a start is accepted, `cs_n_o` is 1, `sclk_o` is 0, `busy_o` is 0, `dq0_oe_o` is 0 and `byte_valid_o` is 0.
- R2: A `start_i` pulse sampled while `busy_o` is 0 and with `count_i` non-zero is accepted. In the following cycle `cs_n_o` is 0, `busy_o` is 1, `dq0_oe_o` is 1 and `sclk_o` is 0.
- R3: The first 32 serial clocks carry 8'h3B followed by `addr_i`, both most significant bit first, on `dq0_o` with `dq0_oe_o` at 1. `dq0_o` changes only on a falling edge of `sclk_o` and is sampled by the flash on the rising edge.
- R4: Exactly eight dummy clocks follow the address. `dq0_oe_o` drops on the falling edge that ends the 32nd clock, which is before the falling edge that starts the first data output clock.
- R5: `dq0_oe_o` stays 0 from the 33rd serial clock until `cs_n_o` returns to 1, and it is 0 whenever `cs_n_o` is 1.
- R6: From the 41st serial clock on, each rising edge samples one bit pair, with `dq1_i` as the higher bit and `dq0_i` as the lower. Four clocks make one byte, and the first pair becomes bits 7:6. Bytes leave in address order.
- R7: Exactly `count_i` bytes are read, so 40 + 4*`count_i` rising edges occur while `cs_n_o` is 0. `cs_n_o` rises on the falling edge that follows the last rising edge, and `sclk_o` is 0 whenever `cs_n_o` is 1.
- R8: While `byte_valid_o` is 1 and `byte_ready_i` is 0, `byte_valid_o` and `byte_data_o` hold. If more rising edges are still due, `sclk_o` also holds.
- R9: `busy_o` is 1 whenever `cs_n_o` is 0 and falls 2*HALF system clocks after `cs_n_o` rises. A start sampled while `busy_o` is 1, or with `count_i` equal to 0, is ignored.
- R10: Each high or low phase of `sclk_o` during a transaction lasts HALF system clocks, not counting the cycles stalled under R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, one cycle |
| addr_i | input | 24 | First byte address, sampled with start |
| count_i | input | CNT_W | Number of bytes to read, sampled with start |
| busy_o | output | 1 | Transaction in progress, including the deselect gap |
| cs_n_o | output | 1 | Flash select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| dq0_o | output | 1 | Command/address bit for the shared line |
| dq0_oe_o | output | 1 | Output enable for the shared line driver |
| dq0_i | input | 1 | Shared line read value (lower bit of a pair) |
| dq1_i | input | 1 | Second data line (higher bit of a pair) |
| byte_data_o | output | 8 | Received byte |
| byte_valid_o | output | 1 | Received byte available |
| byte_ready_i | input | 1 | Consumer accepts the byte |

## Verification
The bench models a flash that follows the serial clock edges. It checks the opcode and address it collects and returns address-derived data, so a wrong dummy count or a swapped line order shows up at once as a wrong byte stream. It holds ready low for long random stretches. A design that kept clocking while its output register was full would overwrite a byte, and the byte comparison or the R8 hold check catches that. It issues single-byte reads and pulses start during a transaction and in the deselect gap. A design that re-launched, dropped `busy_o` too early or miscounted the final clock would produce the wrong number of rising edges or the wrong gap length. It also measures every half period, so a divider that was off by one is caught.

// File: rtl/dual_spi_read_master.sv
module dual_spi_read_master #(
  parameter int HALF  = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [23:0]      addr_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             dq0_o,
  output logic             dq0_oe_o,
  input  logic             dq0_i,
  input  logic             dq1_i,
  output logic [7:0]       byte_data_o,
  output logic             byte_valid_o,
  input  logic             byte_ready_i
);
  localparam int DIV_W     = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [7:0] OPCODE = 8'h3B;
  localparam int HDR_BITS  = 32;
  localparam int DUMMY_CLK = 8;
  localparam logic [5:0] HDR_END  = 6'(HDR_BITS);
  localparam logic [5:0] DATA_IDX = 6'(HDR_BITS + DUMMY_CLK);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TAIL, S_GAP} state_t;

  state_t           state_q;
  logic [DIV_W-1:0] div_q;
  logic [31:0]      sh_q;
  logic [5:0]       idx_q;
  logic [1:0]       pair_q;
  logic [5:0]       rx_q;
  logic [CNT_W-1:0] left_q;
  logic             gap_q;
  logic             sclk_q, cs_n_q, oe_q, valid_q;
  logic [7:0]       data_q;

  wire hold   = (state_q == S_RUN) && valid_q && !byte_ready_i;
  wire tick   = (state_q != S_IDLE) && !hold && (div_q == DIV_W'(HALF - 1));
  wire rise   = tick && !sclk_q;
  wire fall   = tick && sclk_q;
  wire launch = (state_q == S_IDLE) && start_i && (count_i != '0);
  wire [7:0] next_byte = {rx_q, dq1_i, dq0_i};

  assign busy_o       = (state_q != S_IDLE);
  assign cs_n_o       = cs_n_q;
  assign sclk_o       = sclk_q;
  assign dq0_o        = sh_q[31];
  assign dq0_oe_o     = oe_q;
  assign byte_data_o  = data_q;
  assign byte_valid_o = valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      div_q   <= '0;
      sh_q    <= '0;
      idx_q   <= '0;
      pair_q  <= '0;
      rx_q    <= '0;
      left_q  <= '0;
      gap_q   <= 1'b0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      oe_q    <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (valid_q && byte_ready_i) valid_q <= 1'b0;

      if (state_q == S_IDLE || tick) div_q <= '0;
      else if (!hold)                div_q <= div_q + 1'b1;

      case (state_q)
        S_IDLE: if (launch) begin
          state_q <= S_RUN;
          cs_n_q  <= 1'b0;
          oe_q    <= 1'b1;
          sh_q    <= {OPCODE, addr_i};
          idx_q   <= '0;
          pair_q  <= '0;
          left_q  <= count_i;
        end
        S_RUN: begin
          if (tick) sclk_q <= ~sclk_q;
          if (rise) begin
            if (idx_q != DATA_IDX) idx_q <= idx_q + 6'd1;
            else begin
              rx_q   <= next_byte[5:0];
              pair_q <= pair_q + 2'd1;
              if (pair_q == 2'd3) begin
                data_q  <= next_byte;
                valid_q <= 1'b1;
                left_q  <= left_q - CNT_W'(1);
                if (left_q == CNT_W'(1)) state_q <= S_TAIL;
              end
            end
          end
          if (fall) begin
            if (idx_q < HDR_END)  sh_q <= {sh_q[30:0], 1'b0};
            if (idx_q == HDR_END) oe_q <= 1'b0;
          end
        end
        S_TAIL: if (tick) begin
          sclk_q  <= 1'b0;
          cs_n_q  <= 1'b1;
          gap_q   <= 1'b0;
          state_q <= S_GAP;
        end
        default: if (tick) begin
          if (gap_q) state_q <= S_IDLE;
          else       gap_q   <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/dual_spi_read_master_chk.sv
module dual_spi_read_master_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [CNT_W-1:0] count_i,
  input logic             busy_o,
  input logic             cs_n_o,
  input logic             sclk_o,
  input logic             dq0_o,
  input logic             dq0_oe_o,
  input logic [7:0]       byte_data_o,
  input logic             byte_valid_o,
  input logic             byte_ready_i
);
  a_r7_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  a_r5_no_drive_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !dq0_oe_o);

  a_r9_busy_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> busy_o);

  a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && count_i != '0) |=> (!cs_n_o && dq0_oe_o && !sclk_o && busy_o));

  a_r9_zero_count_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && count_i == '0) |=> (cs_n_o && !busy_o));

  a_r3_shift_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && !$past(cs_n_o) && !$fell(sclk_o)) |-> $stable(dq0_o));

  a_r4_release_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq0_oe_o) |-> $fell(sclk_o));

  a_r8_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_o && !byte_ready_i) |=> (byte_valid_o && $stable(byte_data_o)));
endmodule

bind dual_spi_read_master dual_spi_read_master_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_dual_spi_read_master.sv
`timescale 1ns/1ps
module test_dual_spi_read_master;
  localparam int HALF  = 2;
  localparam int CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [CNT_W-1:0] count_i = '0;
  logic busy_o, cs_n_o, sclk_o, dq0_o, dq0_oe_o;
  logic dq0_i = 1'b0, dq1_i = 1'b0;
  logic [7:0] byte_data_o;
  logic byte_valid_o, byte_ready_i = 1'b1;

  always #2.5 clk = ~clk;

  dual_spi_read_master #(.HALF(HALF), .CNT_W(CNT_W)) i_dual_spi_read_master (.*);

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  int ready_mode = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pattern(input logic [23:0] a);
    return a[7:0] ^ {a[15:12], a[19:16]} ^ 8'h5A;
  endfunction

  // behavioural flash
  int rises = 0;
  logic [31:0] cmd_sr = '0;
  logic [23:0] cur_addr = '0;
  int cur_count = 0;
  bit in_txn = 0;
  logic [7:0] exp_q[$];

  always @(negedge cs_n_o) begin rises = 0; cmd_sr = '0; end

  always @(posedge sclk_o) if (!cs_n_o) begin
    if (rises < 32) begin
      cmd_sr = {cmd_sr[30:0], dq0_o};
      check(dq0_oe_o, "R3", "driver enabled in header", dq0_oe_o, 1);
    end
    if (rises == 32)
      check(cmd_sr == {8'h3B, cur_addr}, "R3", "opcode and address", cmd_sr, {8'h3B, cur_addr});
    if (rises >= 40)
      check(!dq0_oe_o, "R5", "driver released in data", dq0_oe_o, 0);
    rises++;
  end

  always @(negedge sclk_o) if (!cs_n_o && rises >= 40) begin
    int p;
    logic [7:0] b, s;
    p = rises - 40;
    b = pattern(24'(cur_addr + 24'(p / 4)));
    s = b >> (6 - 2 * (p % 4));
    {dq1_i, dq0_i} = s[1:0];
    if (rises == 40) check(!dq0_oe_o, "R4", "released before first data fall", dq0_oe_o, 0);
  end

  always @(posedge cs_n_o) if (in_txn)
    check(rises == 40 + 4 * cur_count, "R7", "rising edges per transaction", rises, 40 + 4 * cur_count);

  // consumer
  initial forever begin
    @(posedge clk); #1;
    case (ready_mode)
      0: byte_ready_i = 1'b1;
      1: byte_ready_i = 1'($urandom_range(0, 1));
      default: byte_ready_i = ($urandom_range(0, 7) == 0);
    endcase
  end

  // per-clock reference comparison
  logic prev_sclk = 0, prev_cs = 1, stall_prev = 0;
  logic [7:0] prev_data = '0;
  int half_cnt = 0, gap_cnt = 0;
  bit gap_on = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit toggled;
      toggled = (sclk_o != prev_sclk);
      if (cs_n_o) begin
        check(!sclk_o, "R7", "sclk low while deselected", sclk_o, 0);
        check(!dq0_oe_o, "R5", "no drive while deselected", dq0_oe_o, 0);
      end else
        check(busy_o, "R9", "busy while selected", busy_o, 1);
      if (!cs_n_o && !prev_cs) begin
        if (toggled) begin
          check(half_cnt + 1 == HALF, "R10", "half period", half_cnt + 1, HALF);
          half_cnt = 0;
        end else if (!stall_prev) half_cnt++;
        if (stall_prev && rises < 40 + 4 * cur_count)
          check(!toggled, "R8", "sclk held under backpressure", toggled, 0);
      end else half_cnt = 0;
      if (stall_prev)
        check(byte_valid_o && byte_data_o == prev_data, "R8", "byte held", byte_data_o, prev_data);
      if (cs_n_o && !prev_cs) begin gap_on = 1; gap_cnt = 0; end
      else if (gap_on) begin
        gap_cnt++;
        if (!busy_o) begin
          check(gap_cnt == 2 * HALF, "R9", "deselect gap length", gap_cnt, 2 * HALF);
          gap_on = 0;
        end
      end
      if (byte_valid_o && byte_ready_i) begin
        if (exp_q.size() == 0) check(0, "R7", "unexpected byte", byte_data_o, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(byte_data_o == e, "R6", "byte value", byte_data_o, e);
        end
      end
    end
    stall_prev = byte_valid_o && !byte_ready_i;
    prev_data  = byte_data_o;
    prev_sclk  = sclk_o;
    prev_cs    = cs_n_o;
  end

  task automatic pulse_start(input logic [23:0] a, input int n);
    start_i = 1'b1; addr_i = a; count_i = CNT_W'(n);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_read(input logic [23:0] a, input int n, input bit poke);
    while (busy_o || byte_valid_o) @(negedge clk);
    cur_addr = a; cur_count = n; in_txn = 1;
    for (int i = 0; i < n; i++) exp_q.push_back(pattern(24'(a + 24'(i))));
    pulse_start(a, n);
    check(!cs_n_o && busy_o && dq0_oe_o && !sclk_o, "R2", "start accepted", {cs_n_o, busy_o, dq0_oe_o}, 3'b011);
    if (poke) begin
      repeat (20) @(negedge clk);
      pulse_start(~a, 50);
      while (!cs_n_o) @(negedge clk);
      check(busy_o, "R9", "busy in gap", busy_o, 1);
      pulse_start(a ^ 24'h00F0F0, 7);
      check(cs_n_o, "R9", "start in gap ignored", cs_n_o, 1);
    end
    while (busy_o) @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      check(cs_n_o && !busy_o, "R9", "no relaunch", {cs_n_o, busy_o}, 2'b10);
    end
    while (byte_valid_o) @(negedge clk);
    check(exp_q.size() == 0, "R7", "all bytes delivered", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(cs_n_o && !sclk_o && !busy_o && !dq0_oe_o && !byte_valid_o, "R1", "state in reset",
          {cs_n_o, sclk_o, busy_o, dq0_oe_o, byte_valid_o}, 5'b10000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cs_n_o && !sclk_o && !busy_o && !dq0_oe_o && !byte_valid_o, "R1", "idle after reset",
          {cs_n_o, sclk_o, busy_o, dq0_oe_o, byte_valid_o}, 5'b10000);

    ready_mode = 0; run_read(24'h123456, 4, 0);
    ready_mode = 1; run_read(24'hABCDEF, 9, 0);
    ready_mode = 2; run_read(24'h00FF10, 6, 0);
    ready_mode = 0; run_read(24'hFFFFFF, 1, 0);

    pulse_start(24'h000777, 0);
    repeat (8) begin
      check(cs_n_o && !busy_o, "R9", "zero count ignored", {cs_n_o, busy_o}, 2'b10);
      @(negedge clk);
    end

    ready_mode = 1; run_read(24'h4A0003, 3, 1);
    ready_mode = 2; run_read(24'h0000FE, 5, 0);
    finish_run();
  end
endmodule